// File: doc/BRIEF.md
# Program Counter Sequencer with Branch Resolution

This block owns the program counter of a 32-bit processor and works out, every cycle, where the next instruction comes from. It takes the current instruction's 6-bit opcode and its 16-bit immediate. It also takes two register values read by the register file: one addressed by the Rs field (instruction bits 25:21) and one addressed by the Rd field (instruction bits 20:16). From these it produces the next program counter and a flag that says whether a branch decision chose it.

Four opcodes redirect the flow. The first is a PC-relative jump with a word-scaled immediate. The second is a register-relative jump that adds the Rs value to the sequential address without scaling it. The last two are conditional branches that compare the Rs value against the Rd value, one taking the branch on equality and one on inequality. Every other opcode falls through to the sequential address, PC + 4.

The PC register loads the computed address on each enabled clock edge. It holds its value while the enable is low, and it returns to zero on a synchronous reset.

Top module: `npc_unit`

## Requirements
- R1: When `rst` is 1 at a rising edge, `pc_q` becomes 0x00000000 on that edge. This holds whatever the values of `en`, the opcode and the operands.
- R2: When `rst` is 0 and `en` is 0 at a rising edge, `pc_q` keeps its value, even if a taken branch is presented in that cycle.
- R3: Any opcode other than 111111, 111110, 010000 and 010001 gives `next_pc` = `pc_q` + 4 and `taken` = 0.
- R4: Opcode 111111 always sets `taken` = 1. It gives `next_pc` = `pc_q` + 4 + (sign-extended 16-bit `imm`, shifted left by 2), so negative immediates jump backwards.
- R5: Opcode 111110 always sets `taken` = 1 and gives `next_pc` = `pc_q` + 4 + `rs_val`, with no scaling of `rs_val`. An unaligned value yields an unaligned PC.
- R6: Opcode 010000 sets `taken` = 1 and `next_pc` = the relative target of R4 when `rs_val` equals `rd_val`. Otherwise it gives `taken` = 0 and `next_pc` = `pc_q` + 4.
- R7: Opcode 010001 sets `taken` = 1 and `next_pc` = the relative target of R4 when `rs_val` differs from `rd_val`. Otherwise it gives `taken` = 0 and `next_pc` = `pc_q` + 4.
- R8: When `rst` is 0 and `en` is 1 at a rising edge, `pc_q` takes the value `next_pc` had just before that edge.
- R9: All address sums wrap modulo 2^32. No overflow is flagged.
- R10: `next_pc` and `taken` are combinational functions of the current inputs and `pc_q`. They are valid in the same cycle even while `en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the PC |
| en | input | 1 | PC update enable; 0 stalls the PC |
| op | input | 6 | Opcode of the current instruction |
| imm | input | 16 | Immediate field, instruction bits 15:0 |
| rs_val | input | 32 | Register value addressed by the Rs field |
| rd_val | input | 32 | Register value addressed by the Rd field |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Address selected for the next instruction |
| taken | output | 1 | 1 when a branch decision selected `next_pc` |

## Verification
A stall or a reset can arrive in the same cycle as a taken branch. The bench provokes both by presenting a jump or a satisfied conditional with `en` low, and then again with `rst` high. In each case it judges two things separately. First, `next_pc` and `taken` must still show the branch target before the edge. Second, `pc_q` after the edge must be the held value when stalled, or zero when reset, and never the target.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_JMP_REL = 6'b111111;
    localparam logic [OPC_W-1:0] OPC_JMP_REG = 6'b111110;
    localparam logic [OPC_W-1:0] OPC_BR_EQ   = 6'b010000;
    localparam logic [OPC_W-1:0] OPC_BR_NE   = 6'b010001;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_REL,
        FLOW_REG,
        FLOW_IFEQ,
        FLOW_IFNE
    } flow_e;

    typedef struct packed {
        flow_e kind;
        logic  uses_cmp;
    } flow_dec_t;

    function automatic flow_dec_t classify(input logic [OPC_W-1:0] code);
        flow_dec_t d;
        d.uses_cmp = 1'b0;
        unique case (code)
            OPC_JMP_REL: d.kind = FLOW_REL;
            OPC_JMP_REG: d.kind = FLOW_REG;
            OPC_BR_EQ: begin
                d.kind     = FLOW_IFEQ;
                d.uses_cmp = 1'b1;
            end
            OPC_BR_NE: begin
                d.kind     = FLOW_IFNE;
                d.uses_cmp = 1'b1;
            end
            default:   d.kind = FLOW_SEQ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPC_W-1:0] op,
    output flow_dec_t        dec
);
    always_comb dec = classify(op);
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int XLEN        = 32,
    parameter int IMM_W       = 16,
    parameter int INSTR_BYTES = 4
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  rs_val,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  rel_pc,
    output logic [XLEN-1:0]  reg_pc
);
    localparam int SCALE = $clog2(INSTR_BYTES);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] imm_off;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_trunc
            assign imm_sx = imm[XLEN-1:0];
        end
    endgenerate

    assign imm_off = imm_sx << SCALE;
    assign seq_pc  = pc + XLEN'(INSTR_BYTES);
    assign rel_pc  = seq_pc + imm_off;
    assign reg_pc  = seq_pc + rs_val;
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  flow_dec_t       dec,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rd_val,
    input  logic [XLEN-1:0] seq_pc,
    input  logic [XLEN-1:0] rel_pc,
    input  logic [XLEN-1:0] reg_pc,
    output logic [XLEN-1:0] next_pc,
    output logic            taken
);
    logic same;
    logic cond_ok;

    assign same = (rs_val == rd_val);

    always_comb begin
        cond_ok = 1'b0;
        if (dec.uses_cmp) begin
            cond_ok = (dec.kind == FLOW_IFEQ) ? same : !same;
        end
    end

    always_comb begin
        next_pc = seq_pc;
        taken   = 1'b0;
        unique case (dec.kind)
            FLOW_REL: begin
                next_pc = rel_pc;
                taken   = 1'b1;
            end
            FLOW_REG: begin
                next_pc = reg_pc;
                taken   = 1'b1;
            end
            FLOW_IFEQ, FLOW_IFNE: begin
                if (cond_ok) begin
                    next_pc = rel_pc;
                    taken   = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int IMM_W       = 16,
    parameter int INSTR_BYTES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [OPC_W-1:0]    op,
    input  logic [IMM_W-1:0]    imm,
    input  logic [XLEN-1:0]     rs_val,
    input  logic [XLEN-1:0]     rd_val,
    output logic [XLEN-1:0]     pc_q,
    output logic [XLEN-1:0]     next_pc,
    output logic                taken
);
    flow_dec_t       dec;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] rel_pc;
    logic [XLEN-1:0] reg_pc;

    npc_decode u_dec (
        .op  (op),
        .dec (dec)
    );

    npc_target #(
        .XLEN        (XLEN),
        .IMM_W       (IMM_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_tgt (
        .pc     (pc_q),
        .imm    (imm),
        .rs_val (rs_val),
        .seq_pc (seq_pc),
        .rel_pc (rel_pc),
        .reg_pc (reg_pc)
    );

    npc_select #(
        .XLEN (XLEN)
    ) u_sel (
        .dec     (dec),
        .rs_val  (rs_val),
        .rd_val  (rd_val),
        .seq_pc  (seq_pc),
        .rel_pc  (rel_pc),
        .reg_pc  (reg_pc),
        .next_pc (next_pc),
        .taken   (taken)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (en) begin
            pc_q <= next_pc;
        end
    end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [OPC_W-1:0] op,
    input logic [IMM_W-1:0] imm,
    input logic [XLEN-1:0]  rs_val,
    input logic [XLEN-1:0]  rd_val,
    input logic [XLEN-1:0]  pc_q,
    input logic [XLEN-1:0]  next_pc,
    input logic             taken
);
    logic is_flow_op;
    assign is_flow_op = (op == OPC_JMP_REL) || (op == OPC_JMP_REG) ||
                        (op == OPC_BR_EQ)   || (op == OPC_BR_NE);

    // R1: reset clears the PC on the following edge, whatever else is driven
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (pc_q == '0));

    // R2: a stalled cycle leaves the PC unchanged
    p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pc_q));

    // R8: an enabled cycle loads what next_pc showed before the edge
    p_load_next_r8: assert property (@(posedge clk) disable iff (rst)
        en |=> (pc_q == $past(next_pc)));

    // R3: non-flow opcodes never report a taken branch
    p_seq_only_r3: assert property (@(posedge clk) disable iff (rst)
        !is_flow_op |-> !taken);

    // R4: the relative jump is always taken
    p_rel_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JMP_REL) |-> taken);

    // R5: the register jump is always taken
    p_reg_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JMP_REG) |-> taken);

    // R6: equality branch follows the operand comparison
    p_eq_cond_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BR_EQ) |-> (taken == (rs_val == rd_val)));

    // R7: inequality branch follows the operand comparison
    p_ne_cond_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BR_NE) |-> (taken == (rs_val != rd_val)));

    // R3: whenever nothing is taken the flow is sequential
    p_fall_seq_r3: assert property (@(posedge clk) disable iff (rst)
        !taken |-> (next_pc == pc_q + XLEN'(4)));

    logic unused_imm;
    assign unused_imm = ^imm;
endmodule

bind npc_unit npc_unit_chk #(
    .XLEN  (XLEN),
    .IMM_W (IMM_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .op      (op),
    .imm     (imm),
    .rs_val  (rs_val),
    .rd_val  (rd_val),
    .pc_q    (pc_q),
    .next_pc (next_pc),
    .taken   (taken)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [5:0]  op  = 6'd0;
    logic [15:0] imm = 16'd0;
    logic [31:0] rs_val = 32'd0;
    logic [31:0] rd_val = 32'd0;
    logic [31:0] pc_q;
    logic [31:0] next_pc;
    logic        taken;

    always #2.5 clk = ~clk;

    npc_unit u_dut (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .op      (op),
        .imm     (imm),
        .rs_val  (rs_val),
        .rd_val  (rd_val),
        .pc_q    (pc_q),
        .next_pc (next_pc),
        .taken   (taken)
    );

    typedef struct {
        logic        chk_comb;
        logic [31:0] exp_next;
        logic        exp_taken;
        logic [31:0] exp_pc;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          total = 0;
    int          bad   = 0;
    logic [31:0] model_pc;
    logic        model_ok = 1'b0;
    logic        done = 1'b0;

    task automatic drive(input logic r, input logic e, input logic [5:0] o,
                         input logic [15:0] im, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        item_t       it;
        logic [31:0] seq, rel, tgt;
        logic        tk;
        @(negedge clk);
        rst = r; en = e; op = o; imm = im; rs_val = a; rd_val = b;
        seq = model_pc + 32'd4;
        rel = seq + ({{16{im[15]}}, im} << 2);
        tk  = 1'b0;
        tgt = seq;
        case (o)
            6'b111111: begin tk = 1'b1; tgt = rel; end
            6'b111110: begin tk = 1'b1; tgt = seq + a; end
            6'b010000: if (a == b) begin tk = 1'b1; tgt = rel; end
            6'b010001: if (a != b) begin tk = 1'b1; tgt = rel; end
            default: ;
        endcase
        it.chk_comb  = model_ok;
        it.exp_next  = tgt;
        it.exp_taken = tk;
        it.tag       = tag;
        if (r) it.exp_pc = 32'd0;
        else if (e) it.exp_pc = tgt;
        else it.exp_pc = model_pc;
        sb_q.push_back(it);
        if (r || model_ok) begin
            model_pc = it.exp_pc;
            model_ok = 1'b1;
        end
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                if (it.chk_comb) begin
                    total++;
                    if (next_pc !== it.exp_next) begin
                        bad++;
                        $display("FAIL %s next_pc actual=%h expected=%h", it.tag, next_pc, it.exp_next);
                    end
                    total++;
                    if (taken !== it.exp_taken) begin
                        bad++;
                        $display("FAIL %s taken actual=%b expected=%b", it.tag, taken, it.exp_taken);
                    end
                end
                @(posedge clk);
                #1;
                total++;
                if (pc_q !== it.exp_pc) begin
                    bad++;
                    $display("FAIL %s pc_q actual=%h expected=%h", it.tag, pc_q, it.exp_pc);
                end
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        model_pc = 32'd0;
        // R1 reset state, with a jump presented during reset
        drive(1, 1, 6'b111111, 16'h0010, 0, 0, "R1");
        drive(1, 0, 6'b000000, 16'h0000, 0, 0, "R1");
        // R3 sequential flow and R8 load for several non-branch opcodes
        drive(0, 1, 6'b000000, 16'h1234, 32'h5, 32'h5, "R3_R8");
        drive(0, 1, 6'b100000, 16'hFFFF, 32'h1, 32'h1, "R3");
        drive(0, 1, 6'b110000, 16'h0004, 32'h7, 32'h7, "R3");
        drive(0, 1, 6'b011111, 16'h0001, 32'h9, 32'h9, "R3");
        drive(0, 1, 6'b010010, 16'h0001, 32'h9, 32'h9, "R3");
        // R4 relative jump, forward and backward
        drive(0, 1, 6'b111111, 16'h0003, 0, 0, "R4");
        drive(0, 1, 6'b111111, 16'hFFFE, 0, 0, "R4");
        // R5 register jump, aligned and unaligned, no scaling
        drive(0, 1, 6'b111110, 16'h0040, 32'h0000_0100, 0, "R5");
        drive(0, 1, 6'b111110, 16'h0000, 32'h0000_0003, 0, "R5");
        drive(0, 1, 6'b111110, 16'h0000, 32'hFFFF_FFFF, 0, "R5");
        // R6 equality branch
        drive(0, 1, 6'b010000, 16'h0008, 32'hA5A5_0000, 32'hA5A5_0000, "R6");
        drive(0, 1, 6'b010000, 16'h0008, 32'hA5A5_0000, 32'hA5A5_0001, "R6");
        drive(0, 1, 6'b010000, 16'hFFF0, 32'h0, 32'h0, "R6");
        // R7 inequality branch
        drive(0, 1, 6'b010001, 16'h0005, 32'h1, 32'h2, "R7");
        drive(0, 1, 6'b010001, 16'h0005, 32'h77, 32'h77, "R7");
        drive(0, 1, 6'b010001, 16'h8000, 32'h8000_0000, 32'h0, "R7");
        // R2 stall together with a taken branch; R10 outputs still valid
        drive(0, 0, 6'b111111, 16'h0020, 0, 0, "R2_R10");
        drive(0, 0, 6'b010000, 16'h0001, 32'h3, 32'h3, "R2_R10");
        drive(0, 0, 6'b000000, 16'h0000, 0, 0, "R2");
        // R9 wrap past the top of the address space
        drive(0, 1, 6'b111110, 16'h0000, 32'hFFFF_FF00, 0, "R9");
        drive(0, 1, 6'b111110, 16'h0000, 32'h0000_0200, 0, "R9");
        drive(0, 1, 6'b111111, 16'h7FFF, 0, 0, "R9");
        drive(0, 1, 6'b111110, 16'h0000, 32'hFFFF_FFF0, 0, "R9");
        // R1 reset together with a taken branch and enable
        drive(1, 1, 6'b010001, 16'h0100, 32'h1, 32'h2, "R1");
        drive(0, 1, 6'b000000, 16'h0000, 0, 0, "R1_R8");
        drive(0, 1, 6'b000000, 16'h0000, 0, 0, "R8");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule